// File: doc/BRIEF.md
# Prioritized Stall Cycle Accounting

This block sorts every clock cycle into exactly one accounting bucket and advances that bucket's counter. Each cycle the pipeline presents how many instructions retired and a vector of concurrent flush and stall conditions. A cycle that retires anything is productive. Otherwise the condition nearest the back of the pipeline wins: flushes outrank stalls, and the front-end stall ranks lowest. A cycle with neither retirement nor any condition goes to an "other" bucket. Because exactly one bucket advances per counted cycle, the buckets always add up to the total-cycle counter, which runs alongside them.

All counters are 64 bits wide and are read straight from the output ports. A single clear input zeroes every counter at once.

The design has no state machine. Its only state is the set of counters, which have two named operations: clear and count.

Top module: `cycle_acct`

## Requirements
- R1: After reset every bucket counter and the total counter read zero.
- R2: On every rising edge with `clr_i` low, `total_count_o` increases by exactly one.
- R3: If `retire_cnt_i` is nonzero, bucket 0 (productive) advances, whatever `cond_i` holds.
- R4: With no retirement, the lowest-numbered set bit of `cond_i` selects the bucket, and bucket index = bit + 1. The bits are: 0 branch-mispredict flush, 1 exception/interrupt flush, 2 data-access stall, 3 register-dependency stall, 4 register-stack spill/fill stall, 5 front-end stall.
- R5: With no retirement and `cond_i` all zero, bucket 7 (other) advances.
- R6: Exactly one bucket advances per counted cycle, so the sum of all eight buckets always equals `total_count_o`.
- R7: A rising edge with `clr_i` high sets every counter to zero and counts nothing for that cycle.
- R8: Bucket k is presented on `cat_count_o[64*k+63 : 64*k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all counters |
| retire_cnt_i | input | 3 | Instructions retired this cycle |
| cond_i | input | 6 | Flush and stall condition flags, bit 0 highest priority |
| cat_count_o | output | 512 | Eight 64-bit bucket counters, bucket 0 in the low bits |
| total_count_o | output | 64 | Total counted cycles |

## Verification
The bench aims at the following cases, and each one exposes a specific design error:
- All six conditions active together with a retirement must land in the productive bucket. A design that let a flush take precedence would credit bucket 1 instead.
- Each single condition, and each pair of adjacent conditions, is applied so that every priority boundary is crossed. A swapped or inverted order would credit the lower-priority neighbour.
- A clear applied while conditions are active must leave every counter at zero. A design that counted during a clear would show a one in some bucket and in the total.
- A long random run with sparse flags is compared every cycle against a behavioural model. Any drift in the sum would show up as a mismatch on the total or on one bucket.

// File: rtl/cycle_acct_pkg.sv
package cycle_acct_pkg;
    parameter int NCOND = 6;
    parameter int NCAT  = NCOND + 2;
    typedef enum logic [2:0] {
        CAT_PRODUCTIVE = 3'd0,
        CAT_MISPREDICT = 3'd1,
        CAT_EXCEPTION  = 3'd2,
        CAT_DATA       = 3'd3,
        CAT_DEPEND     = 3'd4,
        CAT_SPILLFILL  = 3'd5,
        CAT_FRONTEND   = 3'd6,
        CAT_OTHER      = 3'd7
    } cat_e;
endpackage

// File: rtl/acct_arbiter.sv
module acct_arbiter
    import cycle_acct_pkg::*;
(
    input  logic             has_retire,
    input  logic [NCOND-1:0] cond,
    output logic [NCAT-1:0]  win
);
    logic found;
    always_comb begin
        win   = '0;
        found = 1'b0;
        if (has_retire) begin
            win[CAT_PRODUCTIVE] = 1'b1;
        end else begin
            for (int b = 0; b < NCOND; b++) begin
                if (cond[b] && !found) begin
                    win[b+1] = 1'b1;
                    found    = 1'b1;
                end
            end
            if (!found) win[CAT_OTHER] = 1'b1;
        end
    end
endmodule

// File: rtl/acct_counter.sv
module acct_counter #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/cycle_acct.sv
module cycle_acct
    import cycle_acct_pkg::*;
#(
    parameter int CW = 64,
    parameter int RW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic [RW-1:0]        retire_cnt_i,
    input  logic [NCOND-1:0]     cond_i,
    output logic [NCAT*CW-1:0]   cat_count_o,
    output logic [CW-1:0]        total_count_o
);
    logic [NCAT-1:0] win;

    acct_arbiter u_arb (
        .has_retire (retire_cnt_i != '0),
        .cond       (cond_i),
        .win        (win)
    );

    for (genvar k = 0; k < NCAT; k++) begin : g_cat
        acct_counter #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_i),
            .inc   (win[k]),
            .count (cat_count_o[k*CW +: CW])
        );
    end

    acct_counter #(.CW(CW)) u_total (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_i),
        .inc   (1'b1),
        .count (total_count_o)
    );
endmodule

// File: rtl/cycle_acct_chk.sv
module cycle_acct_chk
    import cycle_acct_pkg::*;
#(
    parameter int CW = 64,
    parameter int RW = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_i,
    input logic [RW-1:0]      retire_cnt_i,
    input logic [NCOND-1:0]   cond_i,
    input logic [NCAT-1:0]    win,
    input logic [NCAT*CW-1:0] cat_count_o,
    input logic [CW-1:0]      total_count_o
);
    logic [CW-1:0] sum;
    always_comb begin
        sum = '0;
        for (int k = 0; k < NCAT; k++) sum = sum + cat_count_o[k*CW +: CW];
    end

    assert_sum_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sum == total_count_o);

    assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win) == 1);

    assert_total_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> total_count_o == $past(total_count_o) + 1'b1);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> total_count_o == '0 && cat_count_o == '0);

    assert_productive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && retire_cnt_i != '0) |=>
            cat_count_o[0 +: CW] == $past(cat_count_o[0 +: CW]) + 1'b1);

    assert_mispredict_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && retire_cnt_i == '0 && cond_i[0]) |=>
            cat_count_o[CW +: CW] == $past(cat_count_o[CW +: CW]) + 1'b1);

    assert_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && retire_cnt_i == '0 && cond_i == '0) |=>
            cat_count_o[(NCAT-1)*CW +: CW] == $past(cat_count_o[(NCAT-1)*CW +: CW]) + 1'b1);
endmodule

bind cycle_acct cycle_acct_chk #(.CW(CW), .RW(RW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (clr_i),
    .retire_cnt_i  (retire_cnt_i),
    .cond_i        (cond_i),
    .win           (win),
    .cat_count_o   (cat_count_o),
    .total_count_o (total_count_o)
);

// File: tb/cycle_acct_tb.sv
`timescale 1ns/1ps
module cycle_acct_tb;
    localparam int CW = 64;
    localparam int RW = 3;
    localparam int NC = 6;
    localparam int NK = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clr_i = 1'b0;
    logic [RW-1:0]      retire_cnt_i = '0;
    logic [NC-1:0]      cond_i = '0;
    logic [NK*CW-1:0]   cat_count_o;
    logic [CW-1:0]      total_count_o;

    always #2.5 clk = ~clk;

    cycle_acct #(.CW(CW), .RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .retire_cnt_i(retire_cnt_i),
        .cond_i(cond_i), .cat_count_o(cat_count_o), .total_count_o(total_count_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [CW-1:0] m_cnt [NK];
    logic [CW-1:0] m_tot;

    task automatic compare(input string req);
        checks++;
        if (total_count_o !== m_tot) begin
            errors++;
            $display("FAIL %s total: actual %0d expected %0d", req, total_count_o, m_tot);
        end
        for (int k = 0; k < NK; k++) begin
            if (cat_count_o[k*CW +: CW] !== m_cnt[k]) begin
                errors++;
                $display("FAIL %s bucket %0d: actual %0d expected %0d",
                         req, k, cat_count_o[k*CW +: CW], m_cnt[k]);
            end
        end
    endtask

    // drive one cycle, update the model, then compare after the edge
    task automatic step(input logic c, input logic [RW-1:0] r,
                        input logic [NC-1:0] f, input string req);
        int idx;
        clr_i = c; retire_cnt_i = r; cond_i = f;
        if (c) begin
            m_tot = '0;
            for (int k = 0; k < NK; k++) m_cnt[k] = '0;
        end else begin
            m_tot = m_tot + 1;
            if (r != 0) idx = 0;
            else begin
                idx = NK - 1;
                for (int b = NC - 1; b >= 0; b--) if (f[b]) idx = b + 1;
            end
            m_cnt[idx] = m_cnt[idx] + 1;
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        m_tot = '0;
        for (int k = 0; k < NK; k++) m_cnt[k] = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        // R3: retirement beats all conditions
        step(1'b0, 3'd1, 6'b111111, "R3 retire with all flags");
        step(1'b0, 3'd7, 6'b000000, "R3 max retire");
        // R4: each single condition, bucket = bit+1
        for (int b = 0; b < NC; b++) step(1'b0, 3'd0, 6'(1 << b), "R4 single flag");
        // R4: adjacent pairs, lower bit must win
        for (int b = 0; b < NC - 1; b++) step(1'b0, 3'd0, 6'(3 << b), "R4 adjacent pair");
        step(1'b0, 3'd0, 6'b111111, "R4 all flags");
        step(1'b0, 3'd0, 6'b100000, "R4 front-end only");
        // R5: nothing active
        step(1'b0, 3'd0, 6'b000000, "R5 other");
        // R7: clear while busy
        step(1'b1, 3'd2, 6'b111111, "R7 clear");
        step(1'b0, 3'd0, 6'b000100, "R2 count after clear");
        // R6 R8 R2: random run with sparse flags
        for (int i = 0; i < 3000; i++) begin
            logic [RW-1:0] r;
            logic [NC-1:0] f;
            r = ($urandom_range(0, 3) == 0) ? RW'($urandom) : '0;
            f = NC'($urandom & $urandom & $urandom);
            step(($urandom_range(0, 499) == 0), r, f, "R6 random sum");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule